// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block guesses whether a conditional branch will be taken and learns from resolved branches. It holds one 2-bit saturating counter per table slot, and the branch program counter selects the slot. A lookup gives its guess in the same cycle it is presented. A resolved branch moves its counter one step toward the outcome it saw. The counters hold at both ends, so one unusual outcome cannot reverse a strongly held guess. This suits loop branches, which are taken on every pass except the exit.

The table has 2^K slots, where K is a parameter. The slot is chosen by the program counter bits just above the two alignment bits. Branches whose program counters agree in those bits use the same counter, and no tag check separates them. A synchronous reset starts a sweep that writes weakly-taken into one slot per cycle. The training port accepts work only after the sweep has finished.

Training follows valid/ready rules. An update is accepted on a rising clock edge where `upd_valid` and `upd_ready` are both high. `upd_ready` is low only during the reset sweep, and an update offered while it is low is dropped, not held. The caller must therefore keep the update valid until ready returns, or re-issue it. The lookup port has no back-pressure: `pred_valid` only qualifies the `pred_taken` output in the same cycle.

Top module: `bimodal_predictor`

## Requirements
- R1: Each counter is 2 bits wide, with the encoding 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken and 11 strongly taken. When `pred_valid` is high and `upd_ready` is high, `pred_taken` equals bit 1 of the counter that `pred_pc` selects.
- R2: An accepted update with `upd_taken`=1 adds one to the selected counter. A counter already at 11 stays at 11.
- R3: An accepted update with `upd_taken`=0 subtracts one from the selected counter. A counter already at 00 stays at 00, so the counter never wraps in either direction.
- R4: A counter at 11 needs two not-taken updates in a row before the guess becomes not-taken. After one not-taken update the guess is still taken.
- R5: The slot index is PC[K+1:2]. PCs that differ only in bits [1:0], or only in bits above K+1, share one counter, and a change in bit K+1 selects a different counter. With K=12, PC 0x00401A3C selects slot 0x68F.
- R6: After reset every counter holds 10, so a PC that has never been trained is guessed taken.
- R7: After reset is released, `upd_ready` stays low for exactly 2^K clock cycles. It then rises and stays high until the next reset.
- R8: An update offered while `upd_ready` is low changes no counter.
- R9: While `upd_ready` is low, `pred_taken` is 1 whenever `pred_valid` is high.
- R10: When a lookup and an accepted update select the same slot in the same cycle, the lookup returns the counter value from before the update. The new value appears from the next cycle on.
- R11: `pred_taken` is 0 whenever `pred_valid` is low.
- R12: A loop branch that repeats N taken outcomes followed by one not-taken outcome is mispredicted exactly once per loop pass in steady state, and that miss is the exit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; starts the table sweep |
| pred_valid | input | 1 | Lookup request qualifier |
| pred_pc | input | 32 | Program counter of the branch being looked up |
| pred_taken | output | 1 | Taken guess for `pred_pc`, valid in the same cycle |
| upd_valid | input | 1 | Training request valid |
| upd_ready | output | 1 | High once the reset sweep is done; training accepted |
| upd_pc | input | 32 | Program counter of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 for taken |

## Verification
The bench builds the block with the default K=12. With this value it can time the full 4096-cycle sweep, check the index of the worked example, and show that bits 0, 1 and 14 alias while bit 13 does not. The small random pool places its PCs on a few slots, with random alignment bits and random high bits, so that aliased updates and same-slot lookup/update pairs occur often. Directed runs walk single counters through both saturation points and the two-step hysteresis, and replay a loop pattern across several passes.

// File: rtl/bp_pkg.sv
package bp_pkg;

  localparam int PC_W       = 32;
  localparam int ALIGN_BITS = 2;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam ctr_e CTR_INIT = CTR_WT;

  function automatic logic ctr_guess(ctr_e c);
    return c[1];
  endfunction

endpackage

// File: rtl/bp_index.sv
module bp_index
  import bp_pkg::*;
#(
  parameter int K = 12
) (
  input  logic [PC_W-1:0] pc,
  output logic [K-1:0]    idx
);

  initial begin
    if (K < 1 || K > PC_W - ALIGN_BITS) $error("bp_index: K out of range");
  end

  // Alignment bits are dropped; bits above K+1 fold onto the same slot.
  assign idx = K'(pc >> ALIGN_BITS);

endmodule

// File: rtl/bp_ctr_next.sv
module bp_ctr_next
  import bp_pkg::*;
(
  input  ctr_e cur,
  input  logic taken,
  output ctr_e nxt
);

  always_comb begin
    nxt = cur;
    unique case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
      default: nxt = CTR_INIT;
    endcase
  end

endmodule

// File: rtl/bp_init_sweep.sv
module bp_init_sweep #(
  parameter int K = 12
) (
  input  logic         clk,
  input  logic         rst,
  output logic         busy,
  output logic [K-1:0] sweep_idx
);

  localparam logic [K-1:0] IDX_MAX = '1;
  localparam logic [K-1:0] IDX_ONE = K'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_idx <= '0;
      busy      <= 1'b1;
    end else if (busy) begin
      sweep_idx <= sweep_idx + IDX_ONE;
      if (sweep_idx == IDX_MAX) busy <= 1'b0;
    end
  end

  // Ready only rises after the last slot has been written.
  assert_sweep_complete_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(sweep_idx) == IDX_MAX);

  // The sweep visits slots in order, one per cycle.
  assert_sweep_step_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(rst)) |-> sweep_idx == $past(sweep_idx) + IDX_ONE);

  // Once the sweep is done it stays done until reset.
  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(rst)) |=> !busy);

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int K = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [K-1:0] waddr,
  input  ctr_e         wdata,
  input  logic [K-1:0] raddr_a,
  output ctr_e         rdata_a,
  input  logic [K-1:0] raddr_b,
  output ctr_e         rdata_b
);

  localparam int DEPTH = 1 << K;

  ctr_e mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Reads are asynchronous: they show the value from before this cycle's write.
  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // A write is visible on the next cycle at its address.
  assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/bimodal_predictor.sv
module bimodal_predictor
  import bp_pkg::*;
#(
  parameter int K = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pred_valid,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  output logic            upd_ready,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  logic [K-1:0] pred_idx;
  logic [K-1:0] upd_idx;
  logic [K-1:0] sweep_idx;
  logic         busy;
  logic         upd_fire;
  ctr_e         pred_ctr;
  ctr_e         upd_ctr;
  ctr_e         ctr_nxt;
  logic         tbl_we;
  logic [K-1:0] tbl_waddr;
  ctr_e         tbl_wdata;
  logic [1:0]   cur_b;
  logic [1:0]   nxt_b;

  bp_index #(.K(K)) u_pred_index (.pc(pred_pc), .idx(pred_idx));
  bp_index #(.K(K)) u_upd_index  (.pc(upd_pc),  .idx(upd_idx));

  bp_init_sweep #(.K(K)) u_sweep (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .sweep_idx(sweep_idx)
  );

  assign upd_ready = !busy;
  assign upd_fire  = upd_valid && upd_ready;

  bp_ctr_next u_next (
    .cur  (upd_ctr),
    .taken(upd_taken),
    .nxt  (ctr_nxt)
  );

  // The sweep owns the write port until it finishes.
  assign tbl_we    = busy || upd_fire;
  assign tbl_waddr = busy ? sweep_idx : upd_idx;
  assign tbl_wdata = busy ? CTR_INIT  : ctr_nxt;

  bp_ctr_table #(.K(K)) u_table (
    .clk    (clk),
    .rst    (rst),
    .we     (tbl_we),
    .waddr  (tbl_waddr),
    .wdata  (tbl_wdata),
    .raddr_a(pred_idx),
    .rdata_a(pred_ctr),
    .raddr_b(upd_idx),
    .rdata_b(upd_ctr)
  );

  assign pred_taken = pred_valid && (busy ? ctr_guess(CTR_INIT) : ctr_guess(pred_ctr));

  assign cur_b = upd_ctr;
  assign nxt_b = ctr_nxt;

  // Taken moves up by one, holding at the top.
  assert_inc_sat_R2: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && upd_taken) |->
      (cur_b == 2'b11) ? (nxt_b == 2'b11) : (nxt_b == cur_b + 2'd1));

  // Not-taken moves down by one, holding at the bottom.
  assert_dec_sat_R3: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !upd_taken) |->
      (cur_b == 2'b00) ? (nxt_b == 2'b00) : (nxt_b == cur_b - 2'd1));

  // One not-taken from strongly taken keeps the taken guess.
  assert_hysteresis_R4: assert property (@(posedge clk) disable iff (rst)
    (upd_fire && !upd_taken && cur_b == 2'b11) |-> nxt_b[1]);

  // Lookups during the sweep report the reset state's guess.
  assert_sweep_guess_R9: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !upd_ready) |-> pred_taken);

  // No request, no taken guess.
  assert_idle_low_R11: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |-> !pred_taken);

endmodule

// File: tb/bimodal_predictor_tb_top.sv
module bimodal_predictor_tb_top;

  localparam int K     = 12;
  localparam int DEPTH = 1 << K;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pred_valid = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  int mdl [DEPTH];

  always #5 clk = ~clk;

  bimodal_predictor #(.K(K)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .pred_valid(pred_valid),
    .pred_pc   (pred_pc),
    .pred_taken(pred_taken),
    .upd_valid (upd_valid),
    .upd_ready (upd_ready),
    .upd_pc    (upd_pc),
    .upd_taken (upd_taken)
  );

  function automatic int midx(logic [31:0] pc);
    return int'((pc >> 2) % DEPTH);
  endfunction

  function automatic int mguess(logic [31:0] pc);
    return (mdl[midx(pc)] >= 2) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, sample the same-cycle guess, then advance.
  task automatic cyc(bit pv, logic [31:0] ppc, bit uv, logic [31:0] upc, bit ut,
                     output int got);
    pred_valid = pv; pred_pc = ppc;
    upd_valid  = uv; upd_pc  = upc; upd_taken = ut;
    #1;
    got = int'(pred_taken);
    if (uv && upd_ready) begin
      if (ut) mdl[midx(upc)] = (mdl[midx(upc)] == 3) ? 3 : mdl[midx(upc)] + 1;
      else    mdl[midx(upc)] = (mdl[midx(upc)] == 0) ? 0 : mdl[midx(upc)] - 1;
    end
    @(negedge clk);
    pred_valid = 0; upd_valid = 0;
  endtask

  task automatic look(logic [31:0] pc, output int got);
    cyc(1, pc, 0, 32'h0, 0, got);
  endtask

  task automatic train(logic [31:0] pc, bit t);
    int g;
    cyc(0, 32'h0, 1, pc, t, g);
  endtask

  // Reset, then time the sweep while offering an update and a lookup at PC_X.
  task automatic do_reset(logic [31:0] pc_x);
    int n;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    pred_valid = 1; pred_pc = pc_x;
    upd_valid = 1; upd_pc = pc_x; upd_taken = 0;
    n = 0;
    #1;
    while (!upd_ready && n < DEPTH + 20) begin
      if (n == 100) chk("R9 guess during sweep", int'(pred_taken), 1);
      @(negedge clk); #1;
      n++;
    end
    pred_valid = 0; upd_valid = 0;
    chk("R7 sweep length", n, DEPTH);
    for (int i = 0; i < DEPTH; i++) mdl[i] = 2;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int g;
    int miss;
    logic [31:0] pc_a, pc_b, pc_w, pc_x, pc_l, pp, up;
    logic [31:0] pool [8];
    pc_a = 32'h0000_0100;
    pc_b = 32'h0000_0200;
    pc_w = 32'h0040_1A3C;
    pc_x = 32'h0000_1000;
    pc_l = 32'h0000_2000;
    for (int i = 0; i < 8; i++) pool[i] = 32'h0000_0300 + 32'(i * 16);
    void'($urandom(32'd20240611));

    @(negedge clk);
    #1 chk("R7 ready low in reset", int'(upd_ready), 0);
    do_reset(pc_x);

    // R8: the not-taken offered during the sweep must not have landed (still 10).
    look(pc_x, g);  chk("R8 update ignored in sweep", g, 1);
    train(pc_x, 0);
    look(pc_x, g);  chk("R8 counter was at 10", g, 0);

    // R11 and R6
    cyc(0, pc_a, 0, 32'h0, 0, g); chk("R11 idle guess low", g, 0);
    look(pc_a, g);             chk("R6 cold guess taken", g, 1);
    look(32'h0000_7FF8, g);    chk("R6 cold guess taken", g, 1);

    // R2 then R4: saturate high, then step down twice.
    repeat (5) train(pc_a, 1);
    train(pc_a, 0);
    look(pc_a, g); chk("R4 one not-taken keeps taken", g, 1);
    train(pc_a, 0);
    look(pc_a, g); chk("R4 second not-taken flips", g, 0);
    train(pc_a, 1);
    look(pc_a, g); chk("R2 up from 01 to 10 is taken", g, 1);

    // R3: saturate low, a single taken stays not-taken.
    repeat (6) train(pc_a, 0);
    train(pc_a, 1);
    look(pc_a, g); chk("R3 no wrap at 00", g, 0);
    train(pc_a, 1);
    look(pc_a, g); chk("R3 two takens from 00 flip", g, 1);

    // R1: each state's guess is bit 1.
    repeat (4) train(pc_a, 0);
    look(pc_a, g); chk("R1 state 00 guess", g, 0);
    train(pc_a, 1);
    look(pc_a, g); chk("R1 state 01 guess", g, 0);
    train(pc_a, 1);
    look(pc_a, g); chk("R1 state 10 guess", g, 1);
    train(pc_a, 1);
    look(pc_a, g); chk("R1 state 11 guess", g, 1);

    // R5: slot 0x68F for PC 0x00401A3C; aliases on bits 0,1 and 14, not bit 13.
    chk("R5 model index", midx(pc_w), 32'h68F);
    train(pc_w, 0); train(pc_w, 0);
    look(pc_w | 32'h3, g);          chk("R5 alias low bits", g, 0);
    look(pc_w + 32'h0000_4000, g);  chk("R5 alias bit 14", g, 0);
    look(pc_w ^ 32'h0000_2000, g);  chk("R5 bit 13 separate", g, 1);
    look(pc_w + 32'h4, g);          chk("R5 neighbour slot", g, 1);

    // R10: same-cycle lookup sees old value, next cycle sees new.
    cyc(1, pc_b, 1, pc_b, 0, g); chk("R10 same-cycle old value", g, 1);
    look(pc_b, g);               chk("R10 new value next cycle", g, 0);

    // R12: loop of 7 taken then exit, 6 passes.
    for (int p = 0; p < 6; p++) begin
      miss = 0;
      for (int it = 0; it < 8; it++) begin
        cyc(1, pc_l, 1, pc_l, (it < 7), g);
        if (g != int'(it < 7)) miss++;
      end
      if (p > 0) chk("R12 misses per loop pass", miss, 1);
    end

    // Random traffic on a small aliased pool, R1/R2/R3/R10 against the model.
    for (int c = 0; c < 3000; c++) begin
      bit pv, uv, ut;
      pp = pool[$urandom_range(7)] | 32'($urandom_range(3)) | (32'($urandom_range(3)) << 14);
      up = pool[$urandom_range(7)] | 32'($urandom_range(3)) | (32'($urandom_range(3)) << 20);
      if ($urandom_range(3) == 0) up = pp;
      pv = ($urandom_range(3) != 0);
      uv = ($urandom_range(1) == 1);
      ut = ($urandom_range(2) != 0);
      g = pv ? mguess(pp) : 0;
      begin
        int got;
        cyc(pv, pp, uv, up, ut, got);
        chk("R1 R2 R3 R10 random guess", got, g);
      end
    end

    // R6 again after a second reset: trained slots return to weakly taken.
    do_reset(pc_x);
    look(pc_a, g);        chk("R6 re-init after reset", g, 1);
    train(pc_a, 0);
    look(pc_a, g);        chk("R6 re-init state is 10", g, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule